// File: doc/BRIEF.md
# Symbolic Store Buffer with Forwarding

This block holds the stores a transaction makes while one or more of its values are being tracked symbolically. Each held entry records the target address, the concrete value computed during execution and, when the source register was tracked, a symbolic form of that value. The symbolic form is "input slot plus constant offset": the slot names a buffered input word, and the offset is what the transaction added to it. None of the held writes reaches the cache before commit.

A load whose address matches a held entry is served from the buffer. It receives the concrete value together with the symbolic form, so the loading register keeps its tracking. At commit, the surrounding logic first gets fresh values for the tracked inputs. It presents each one on the repair port, and every entry that refers to that slot recomputes its value as the fresh input plus its stored offset. A commit pulse then drains the entries, oldest first, toward the cache. An abort discards every entry without writing any of them.

Top module: `symstore_buf`

## Requirements
- R1: When `st_valid` is high in fill mode and the buffer is not full, a new entry is added after the existing ones. The entry holds `st_addr` and `st_data`, and a load can see it from the next cycle. If `st_sym_vld` is high the entry also keeps `st_sym_idx` and `st_sym_off`. If it is low, the symbolic index and offset are stored as zero.
- R2: `ld_hit` is high when `ld_addr` equals the address of a held entry. The load outputs depend only on `ld_addr` and the held entries, with no clock between them. On a hit, `ld_data`, `ld_sym_vld`, `ld_sym_idx` and `ld_sym_off` give that entry's concrete value and symbolic form. On a miss all four are zero.
- R3: When more than one held entry matches `ld_addr`, the most recently added one is forwarded.
- R4: `st_full` is high exactly when `DEPTH` entries are held. A store presented while the buffer is full is dropped and changes no entry.
- R5: `dr_valid` stays low until a commit is accepted. A commit is accepted only when at least one entry is held after that cycle's store.
- R6: A pulse on `rep_valid` in fill mode updates every held entry whose symbolic form is valid and whose index equals `rep_idx`. Each such entry's concrete value becomes `rep_val` plus its offset, modulo 2^`DATA_W`. All other entries keep their value. A store in the same cycle as a repair pulse is not repaired by it.
- R7: In drain mode, `dr_valid` is high and `dr_addr`/`dr_data` show the oldest held entry. Each cycle with `dr_ready` high removes that entry. The signals stay stable while `dr_ready` is low. Fill mode returns in the cycle after the last entry leaves.
- R8: While draining, stores, repair pulses and further commits are ignored.
- R9: `abort` clears every entry and returns to fill mode in the next cycle without draining. It takes priority over every other input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store allocate request |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Concrete store value |
| st_sym_vld | input | 1 | Source register carries a symbolic form |
| st_sym_idx | input | IDX_W | Input slot of the symbolic form |
| st_sym_off | input | DATA_W | Constant offset of the symbolic form |
| st_full | output | 1 | Buffer full; stores are stalled |
| ld_addr | input | ADDR_W | Load lookup address |
| ld_hit | output | 1 | A held entry matches the load |
| ld_data | output | DATA_W | Forwarded concrete value |
| ld_sym_vld | output | 1 | Forwarded symbolic form is valid |
| ld_sym_idx | output | IDX_W | Forwarded input slot |
| ld_sym_off | output | DATA_W | Forwarded offset |
| rep_valid | input | 1 | Repair update pulse |
| rep_idx | input | IDX_W | Input slot being refreshed |
| rep_val | input | DATA_W | Fresh value of that input |
| commit | input | 1 | Start draining held entries |
| abort | input | 1 | Discard all entries |
| dr_valid | output | 1 | Drain write valid |
| dr_addr | output | ADDR_W | Drain write address |
| dr_data | output | DATA_W | Drain write value (repaired) |
| dr_ready | input | 1 | Cache accepts the drain write |

## Verification
The bench builds the buffer with `DEPTH` = 4, `ADDR_W` = 8, `DATA_W` = 8 and `IDX_W` = 2. The shallow depth lets a few stores fill the buffer, so the stall and the dropped store can be tested. The 8-bit data width lets a repair wrap around when a fresh input plus its offset overflows. The two-bit slot index allows entries that name different inputs to share one address. This shows that a repair changes only the entries tied to its slot, and that forwarding keeps picking the youngest entry after a repair.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
   typedef enum logic {
      MODE_FILL  = 1'b0,
      MODE_DRAIN = 1'b1
   } ssb_mode_e;
endpackage

// File: rtl/ssb_young_sel.sv
// Picks the highest-index set bit of a hit vector (youngest entry).
module ssb_young_sel #(
   parameter int N     = 32,
   parameter int SEL_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     hit,
   output logic             any,
   output logic [SEL_W-1:0] sel
);
   generate
      if (N == 1) begin : g_single
         assign any = hit[0];
         assign sel = '0;
      end else begin : g_multi
         always_comb begin
            sel = '0;
            for (int i = 0; i < N; i++) begin
               if (hit[i]) sel = SEL_W'(i);
            end
         end
         assign any = |hit;
      end
   endgenerate
endmodule

// File: rtl/ssb_fix_lane.sv
// Per-entry repair: recompute value as fresh input plus stored offset.
module ssb_fix_lane #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 3
) (
   input  logic              live,
   input  logic              sym_vld,
   input  logic [IDX_W-1:0]  sym_idx,
   input  logic [DATA_W-1:0] sym_off,
   input  logic [DATA_W-1:0] cur_data,
   input  logic              rep_valid,
   input  logic [IDX_W-1:0]  rep_idx,
   input  logic [DATA_W-1:0] rep_val,
   output logic [DATA_W-1:0] nxt_data
);
   logic take;
   assign take     = rep_valid && live && sym_vld && (sym_idx == rep_idx);
   assign nxt_data = take ? (rep_val + sym_off) : cur_data;
endmodule

// File: rtl/symstore_buf.sv
module symstore_buf
   import ssb_pkg::*;
#(
   parameter int DEPTH  = 32,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_valid,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [DATA_W-1:0] st_data,
   input  logic              st_sym_vld,
   input  logic [IDX_W-1:0]  st_sym_idx,
   input  logic [DATA_W-1:0] st_sym_off,
   output logic              st_full,
   input  logic [ADDR_W-1:0] ld_addr,
   output logic              ld_hit,
   output logic [DATA_W-1:0] ld_data,
   output logic              ld_sym_vld,
   output logic [IDX_W-1:0]  ld_sym_idx,
   output logic [DATA_W-1:0] ld_sym_off,
   input  logic              rep_valid,
   input  logic [IDX_W-1:0]  rep_idx,
   input  logic [DATA_W-1:0] rep_val,
   input  logic              commit,
   input  logic              abort,
   output logic              dr_valid,
   output logic [ADDR_W-1:0] dr_addr,
   output logic [DATA_W-1:0] dr_data,
   input  logic              dr_ready
);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int SEL_W = $clog2(DEPTH);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("symstore_buf: DEPTH must be at least 2");
      end
      if (ADDR_W < 1 || DATA_W < 1 || IDX_W < 1) begin : g_bad_width
         $error("symstore_buf: widths must be positive");
      end
   endgenerate

   // entry storage, index 0 is the oldest
   logic [ADDR_W-1:0] e_addr [DEPTH];
   logic [DATA_W-1:0] e_data [DEPTH];
   logic              e_sv   [DEPTH];
   logic [IDX_W-1:0]  e_idx  [DEPTH];
   logic [DATA_W-1:0] e_off  [DEPTH];
   logic [DATA_W-1:0] fix_data [DEPTH];

   logic [CNT_W-1:0] count, count_after;
   ssb_mode_e        mode;
   logic             full, fill_en, shift_en, store_en;

   assign full     = (count == FULL_CNT);
   assign fill_en  = (mode == MODE_FILL) && !abort;
   assign shift_en = (mode == MODE_DRAIN) && dr_ready && !abort;
   assign store_en = fill_en && st_valid && !full;
   assign count_after = store_en ? count + 1'b1 : count;

   // repair lanes and forwarding hit vector
   logic [DEPTH-1:0] hit_vec;
   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_lane
         logic live;
         assign live       = (CNT_W'(g) < count);
         assign hit_vec[g] = live && (e_addr[g] == ld_addr);
         ssb_fix_lane #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_fix (
            .live      (live),
            .sym_vld   (e_sv[g]),
            .sym_idx   (e_idx[g]),
            .sym_off   (e_off[g]),
            .cur_data  (e_data[g]),
            .rep_valid (rep_valid),
            .rep_idx   (rep_idx),
            .rep_val   (rep_val),
            .nxt_data  (fix_data[g])
         );
      end
   endgenerate

   logic             fwd_any;
   logic [SEL_W-1:0] fwd_sel;
   ssb_young_sel #(.N(DEPTH), .SEL_W(SEL_W)) u_sel (
      .hit (hit_vec),
      .any (fwd_any),
      .sel (fwd_sel)
   );

   assign ld_hit     = fwd_any;
   assign ld_data    = fwd_any ? e_data[fwd_sel] : '0;
   assign ld_sym_vld = fwd_any ? e_sv[fwd_sel]   : 1'b0;
   assign ld_sym_idx = fwd_any ? e_idx[fwd_sel]  : '0;
   assign ld_sym_off = fwd_any ? e_off[fwd_sel]  : '0;

   // control state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         mode  <= MODE_FILL;
      end else if (abort) begin
         count <= '0;
         mode  <= MODE_FILL;
      end else if (mode == MODE_DRAIN) begin
         if (dr_ready) begin
            count <= count - 1'b1;
            if (count == CNT_W'(1)) mode <= MODE_FILL;
         end
      end else begin
         count <= count_after;
         if (commit && count_after != '0) mode <= MODE_DRAIN;
      end
   end

   // entry datapath
   always_ff @(posedge clk) begin
      if (shift_en) begin
         for (int i = 0; i < DEPTH - 1; i++) begin
            e_addr[i] <= e_addr[i+1];
            e_data[i] <= e_data[i+1];
            e_sv[i]   <= e_sv[i+1];
            e_idx[i]  <= e_idx[i+1];
            e_off[i]  <= e_off[i+1];
         end
      end else if (fill_en) begin
         for (int i = 0; i < DEPTH; i++) begin
            if (store_en && CNT_W'(i) == count) begin
               e_addr[i] <= st_addr;
               e_data[i] <= st_data;
               e_sv[i]   <= st_sym_vld;
               e_idx[i]  <= st_sym_vld ? st_sym_idx : '0;
               e_off[i]  <= st_sym_vld ? st_sym_off : '0;
            end else begin
               e_data[i] <= fix_data[i];
            end
         end
      end
   end

   assign st_full  = full;
   assign dr_valid = (mode == MODE_DRAIN);
   assign dr_addr  = e_addr[0];
   assign dr_data  = e_data[0];
endmodule

// File: rtl/ssb_chk.sv
module ssb_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              st_valid,
   input logic              st_full,
   input logic              commit,
   input logic              abort,
   input logic              dr_valid,
   input logic              dr_ready,
   input logic [ADDR_W-1:0] dr_addr,
   input logic [DATA_W-1:0] dr_data,
   input logic              ld_hit
);
   // R5
   no_early_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dr_valid && !commit) |=> !dr_valid);

   // R9
   abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (!dr_valid && !ld_hit && !st_full));

   // R7
   drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dr_valid && !dr_ready && !abort) |=>
         (dr_valid && $stable(dr_addr) && $stable(dr_data)));

   // R4
   full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_full && !dr_valid && !abort && !commit) |=> st_full);

   // R8
   drain_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dr_valid && !dr_ready && !abort && st_valid) |=> $stable(dr_addr));
endmodule

bind symstore_buf ssb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ssb_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .st_valid (st_valid),
   .st_full  (st_full),
   .commit   (commit),
   .abort    (abort),
   .dr_valid (dr_valid),
   .dr_ready (dr_ready),
   .dr_addr  (dr_addr),
   .dr_data  (dr_data),
   .ld_hit   (ld_hit)
);

// File: tb/test_symstore_buf.sv
module test_symstore_buf;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 4, ADDR_W = 8, DATA_W = 8, IDX_W = 2;
   localparam int MASK = (1 << DATA_W) - 1;

   logic clk = 0, rst_n = 0;
   logic st_valid = 0, st_sym_vld = 0, rep_valid = 0, commit = 0, abort = 0, dr_ready = 0;
   logic [ADDR_W-1:0] st_addr = 0, ld_addr = 0;
   logic [DATA_W-1:0] st_data = 0, st_sym_off = 0, rep_val = 0;
   logic [IDX_W-1:0]  st_sym_idx = 0, rep_idx = 0;
   logic st_full, ld_hit, ld_sym_vld, dr_valid;
   logic [DATA_W-1:0] ld_data, ld_sym_off, dr_data;
   logic [IDX_W-1:0]  ld_sym_idx;
   logic [ADDR_W-1:0] dr_addr;

   always #(CLK_PERIOD/2) clk = ~clk;

   symstore_buf #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) i_symstore_buf (
      .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
      .st_sym_vld(st_sym_vld), .st_sym_idx(st_sym_idx), .st_sym_off(st_sym_off), .st_full(st_full),
      .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data), .ld_sym_vld(ld_sym_vld),
      .ld_sym_idx(ld_sym_idx), .ld_sym_off(ld_sym_off), .rep_valid(rep_valid), .rep_idx(rep_idx),
      .rep_val(rep_val), .commit(commit), .abort(abort), .dr_valid(dr_valid), .dr_addr(dr_addr),
      .dr_data(dr_data), .dr_ready(dr_ready));

   typedef struct { int addr; int data; bit sv; int idx; int off; } ment_t;
   ment_t mq[$];
   bit    m_drain = 0;
   int    n_cmp = 0, n_bad = 0;
   string cur_req = "R5";

   task automatic cmp(string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
      end
   endtask

   task automatic compare_all();
      int f = -1;
      for (int i = mq.size() - 1; i >= 0; i--) if (f < 0 && mq[i].addr == int'(ld_addr)) f = i;
      cmp("st_full(R4)", int'(st_full), int'(mq.size() == DEPTH));
      cmp("dr_valid(R5)", int'(dr_valid), int'(m_drain));
      if (m_drain) begin
         cmp("dr_addr(R7)", int'(dr_addr), mq[0].addr);
         cmp("dr_data(R7)", int'(dr_data), mq[0].data);
      end
      cmp("ld_hit(R2)", int'(ld_hit), int'(f >= 0));
      cmp("ld_data(R3)", int'(ld_data), f >= 0 ? mq[f].data : 0);
      cmp("ld_sym_vld(R1)", int'(ld_sym_vld), f >= 0 ? int'(mq[f].sv) : 0);
      cmp("ld_sym_idx(R1)", int'(ld_sym_idx), f >= 0 ? mq[f].idx : 0);
      cmp("ld_sym_off(R1)", int'(ld_sym_off), f >= 0 ? mq[f].off : 0);
   endtask

   task automatic model_step();
      if (abort) begin
         mq.delete(); m_drain = 0;
      end else if (m_drain) begin
         if (dr_ready) begin
            void'(mq.pop_front());
            if (mq.size() == 0) m_drain = 0;
         end
      end else begin
         if (rep_valid)
            foreach (mq[i]) if (mq[i].sv && mq[i].idx == int'(rep_idx))
               mq[i].data = (int'(rep_val) + mq[i].off) & MASK;
         if (st_valid && mq.size() < DEPTH) begin
            ment_t e;
            e.addr = int'(st_addr); e.data = int'(st_data); e.sv = st_sym_vld;
            e.idx = st_sym_vld ? int'(st_sym_idx) : 0;
            e.off = st_sym_vld ? int'(st_sym_off) : 0;
            mq.push_back(e);
         end
         if (commit && mq.size() != 0) m_drain = 1;
      end
   endtask

   task automatic tick();
      #1; compare_all(); model_step();
      @(posedge clk); @(negedge clk);
      st_valid = 0; rep_valid = 0; commit = 0; abort = 0;
   endtask

   task automatic do_store(int a, int d, bit sv, int idx, int off);
      st_valid = 1; st_addr = ADDR_W'(a); st_data = DATA_W'(d);
      st_sym_vld = sv; st_sym_idx = IDX_W'(idx); st_sym_off = DATA_W'(off);
      tick();
   endtask

   task automatic do_load(int a);
      ld_addr = ADDR_W'(a); tick();
   endtask

   task automatic do_repair(int idx, int v);
      rep_valid = 1; rep_idx = IDX_W'(idx); rep_val = DATA_W'(v); tick();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
      // reset state and no drain before commit
      cur_req = "R5"; do_load(8'h05); tick();
      commit = 1; tick();                       // R5: commit on empty buffer ignored
      // R1 / R2: allocation, tagged and untagged, hit and miss
      cur_req = "R1"; do_store(8'h10, 3, 1, 1, 1); do_store(8'h20, 7, 0, 3, 9);
      do_load(8'h10); do_load(8'h20);
      cur_req = "R2"; do_load(8'h30);
      // R3: youngest of two same-address entries forwards
      cur_req = "R3"; do_store(8'h10, 9, 1, 2, 3); do_load(8'h10);
      // R4: fill, then a dropped store
      cur_req = "R4"; do_store(8'h40, 1, 1, 1, 2); do_store(8'h50, 4, 1, 0, 0);
      do_load(8'h50); do_load(8'h40);
      // R6: repair slot 1 with value 4, then slot 2 with wrap
      cur_req = "R6"; ld_addr = 8'h40; do_repair(1, 4); tick();
      ld_addr = 8'h20; tick();
      ld_addr = 8'h10; do_repair(2, 8'hFF); tick();
      // R7 / R8: drain with back-pressure and ignored inputs
      cur_req = "R7"; commit = 1; tick();
      for (int k = 0; k < 12; k++) begin
         cur_req = (k % 3 == 1) ? "R8" : "R7";
         dr_ready = (k % 2 == 1);
         st_valid = 1; st_addr = 8'h60; st_data = 8'h11; st_sym_vld = 0;
         rep_valid = 1; rep_idx = 1; rep_val = 8'h20; commit = 1;
         ld_addr = 8'h10; tick();
      end
      dr_ready = 0;
      cur_req = "R8"; do_load(8'h60);
      // R9: abort beats a same-cycle store, then abort mid-drain
      cur_req = "R9"; do_store(8'h70, 5, 1, 0, 1);
      abort = 1; st_valid = 1; st_addr = 8'h71; do_load(8'h70); do_load(8'h71);
      do_store(8'h72, 6, 0, 0, 0); do_store(8'h73, 7, 1, 3, 4);
      commit = 1; tick(); dr_ready = 1; tick(); dr_ready = 0;
      abort = 1; tick(); do_load(8'h73); tick();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule